// File: doc/BRIEF.md
# Bus transfer-type start decoder

This block sits next to the single target of a processor bus and sorts every new transfer at its start. When the active-low transfer-start strobe is sampled low, the block reads the 5-bit transfer-type code. It then sets one of two active-low results. The claim output says the memory controller will serve the transfer. The error output says a downstream cycle engine must end the transfer with a transfer-error acknowledge.

For a claimed transfer, an active-low write qualifier gives the direction. Only four transfer-type codes are served. Any other code is actively answered with the error output, because the processor would otherwise wait forever. The processor holds the transfer-type code steady for the whole address tenure, so the code is sampled only on the start edge.

All outputs are registered. They hold their value until the address acknowledge for that transfer is sampled low. Starts that arrive while a transfer is still held are ignored. The block assumes a single-processor system with no snooping.

Top module: `xfer_start_decode`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, `claimN`, `errN` and `writeN` are all 1 at the next clock edge.
- R2: A start with `ttCode` = 5'b00010 (`ttCode[4]` is the most significant bit) gives `claimN`=0, `errN`=1, `writeN`=0.
- R3: A start with `ttCode` = 5'b00110 gives `claimN`=0, `errN`=1, `writeN`=0.
- R4: A start with `ttCode` = 5'b01010 gives `claimN`=0, `errN`=1, `writeN`=1.
- R5: A start with `ttCode` = 5'b01110 gives `claimN`=0, `errN`=1, `writeN`=1.
- R6: A start with any of the other 28 codes gives `errN`=0, `claimN`=1, `writeN`=1. Every accepted start therefore yields exactly one of claim or error.
- R7: The outputs change on the first rising edge at which `startN` is sampled low while the block is idle. Idle means `claimN`=1 and `errN`=1.
- R8: While claim or error is active, all three outputs hold their values until `addrAckN` is sampled low. On that edge all three outputs return to 1.
- R9: A low `startN` is ignored while a transfer is held, including on the edge that releases it.
- R10: `claimN` and `errN` are never 0 together, and `writeN` is 0 only while `claimN` is 0.
- R11: While the block is idle, a low `addrAckN` has no effect, and the outputs stay at 1 when `startN` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| startN | input | 1 | Transfer-start strobe, active low |
| addrAckN | input | 1 | Address acknowledge, active low |
| ttCode | input | 5 | Transfer-type code, bit 4 is the first (most significant) bit |
| claimN | output | 1 | Transfer is served, active low |
| errN | output | 1 | Transfer must be error-terminated, active low |
| writeN | output | 1 | Claimed transfer is a write, active low |

## Verification
The checker module checks the following on every cycle:
- claim and error are never active together, and the write qualifier is active only while claim is active;
- an idle start always produces a result;
- a held result stays stable until the address acknowledge, and the acknowledge releases it;
- with no start, the block stays idle.

Which specific code maps to claim, read or write, and that a second start during a hold is ignored, are shown by the bench. The bench sweeps all 32 codes, issues an intruding start with a different code during each hold, and checks acknowledges given while idle. A behavioural reference model is compared against all three outputs on every clock.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture decode of the current code
    logic clear;  // return outputs to inactive
  } xferStrobe_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startN,
  input  logic        addrAckN,
  output xferStrobe_t strobes
);
  logic busyQ;

  always_comb begin
    strobes.load  = !busyQ && !startN;
    strobes.clear = busyQ && !addrAckN;
  end

  always_ff @(posedge clk) begin
    if (rst)                busyQ <= 1'b0;
    else if (strobes.clear) busyQ <= 1'b0;
    else if (strobes.load)  busyQ <= 1'b1;
  end
endmodule

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_pkg::*;
#(
  parameter int TT_W = 5,
  parameter logic [TT_W-1:0] CODE_WR_FLUSH = 5'b00010,
  parameter logic [TT_W-1:0] CODE_WR_KILL  = 5'b00110,
  parameter logic [TT_W-1:0] CODE_RD       = 5'b01010,
  parameter logic [TT_W-1:0] CODE_RD_RWITM = 5'b01110
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TT_W-1:0] ttCode,
  input  xferStrobe_t     strobes,
  output logic            claimN,
  output logic            errN,
  output logic            writeN
);
  localparam int NUM_CODES = 4;
  localparam logic [NUM_CODES*TT_W-1:0] CODE_LIST =
    {CODE_RD_RWITM, CODE_RD, CODE_WR_KILL, CODE_WR_FLUSH};
  localparam logic [NUM_CODES-1:0] CODE_IS_WRITE = 4'b0011;

  logic [NUM_CODES-1:0] hitVec;
  logic accepted;
  logic isWrite;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_match
    assign hitVec[g] = (ttCode == CODE_LIST[g*TT_W +: TT_W]);
  end

  assign accepted = |hitVec;
  assign isWrite  = |(hitVec & CODE_IS_WRITE);

  logic claimQ, errQ, writeQ;

  always_ff @(posedge clk) begin
    if (rst || strobes.clear) begin
      claimQ <= 1'b1;
      errQ   <= 1'b1;
      writeQ <= 1'b1;
    end else if (strobes.load) begin
      claimQ <= !accepted;
      errQ   <= accepted;
      writeQ <= !isWrite;
    end
  end

  assign claimN = claimQ;
  assign errN   = errQ;
  assign writeN = writeQ;
endmodule

// File: rtl/xfer_start_decode.sv
module xfer_start_decode
  import xfer_pkg::*;
#(
  parameter int TT_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            startN,
  input  logic            addrAckN,
  input  logic [TT_W-1:0] ttCode,
  output logic            claimN,
  output logic            errN,
  output logic            writeN
);
  xferStrobe_t strobes;

  xfer_ctrl i_ctrl (
    .clk(clk), .rst(rst), .startN(startN), .addrAckN(addrAckN), .strobes(strobes)
  );

  xfer_dp #(.TT_W(TT_W)) i_dp (
    .clk(clk), .rst(rst), .ttCode(ttCode), .strobes(strobes),
    .claimN(claimN), .errN(errN), .writeN(writeN)
  );
endmodule

// File: rtl/xfer_start_decode_checker.sv
module xfer_start_decode_checker (
  input logic clk,
  input logic rst,
  input logic startN,
  input logic addrAckN,
  input logic claimN,
  input logic errN,
  input logic writeN
);
  // R10
  a_r10_claim_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(!claimN && !errN));
  // R10
  a_r10_write_needs_claim: assert property (@(posedge clk) disable iff (rst)
    !writeN |-> !claimN);
  // R6, R7: an idle start is always answered
  a_r7_start_answered: assert property (@(posedge clk) disable iff (rst)
    (!startN && claimN && errN) |=> (claimN != errN));
  // R8: held until acknowledge
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    ((!claimN || !errN) && addrAckN) |=> $stable({claimN, errN, writeN}));
  // R8: released by acknowledge
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    ((!claimN || !errN) && !addrAckN) |=> (claimN && errN && writeN));
  // R11: idle without start stays idle
  a_r11_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (claimN && errN && startN) |=> (claimN && errN && writeN));
endmodule

bind xfer_start_decode xfer_start_decode_checker i_chk (
  .clk(clk), .rst(rst), .startN(startN), .addrAckN(addrAckN),
  .claimN(claimN), .errN(errN), .writeN(writeN)
);

// File: tb/test_xfer_start_decode.sv
module test_xfer_start_decode;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startN = 1'b1;
  logic addrAckN = 1'b1;
  logic [4:0] ttCode = '0;
  logic claimN, errN, writeN;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit compareOn = 1'b0;
  string curReq = "R1";

  // reference model state: {claim, err, write}
  logic [2:0] model = 3'b111;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_start_decode i_xfer_start_decode (
    .clk(clk), .rst(rst), .startN(startN), .addrAckN(addrAckN), .ttCode(ttCode),
    .claimN(claimN), .errN(errN), .writeN(writeN)
  );

  function automatic logic [2:0] expectFor(input logic [4:0] c);
    if (c == 5'd2 || c == 5'd6)        return 3'b010;
    else if (c == 5'd10 || c == 5'd14) return 3'b011;
    else                               return 3'b101;
  endfunction

  function automatic string reqFor(input logic [4:0] c);
    case (c)
      5'd2:    return "R2";
      5'd6:    return "R3";
      5'd10:   return "R4";
      5'd14:   return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) model = 3'b111;
    else if (model[2] == 1'b0 || model[1] == 1'b0) begin
      if (!addrAckN) model = 3'b111;
    end else if (!startN) model = expectFor(ttCode);
    compareOn = 1'b1;
  end

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (claimN,errN,writeN) t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, plus R10 exclusivity
  always @(negedge clk) begin
    if (compareOn) begin
      chk(curReq, {claimN, errN, writeN}, model);
      checks++;
      if (claimN === 1'b0 && errN === 1'b0) begin
        failures++;
        $display("FAIL R10 actual=claimN0_errN0 expected=not_both_low t=%0t", $time);
      end
    end
  end

  task automatic xfer(input logic [4:0] code, input int hold);
    logic [2:0] exp;
    exp = expectFor(code);
    curReq = reqFor(code);
    startN = 1'b0; ttCode = code;
    @(negedge clk);                               // R7: result visible after one edge
    chk(reqFor(code), {claimN, errN, writeN}, exp);
    startN = 1'b1;
    curReq = "R8";
    for (int i = 0; i < hold; i++) @(negedge clk);
    chk("R8", {claimN, errN, writeN}, exp);
    curReq = "R9";                                // intruding start with another code
    startN = 1'b0; ttCode = code ^ 5'b11111;
    @(negedge clk);
    chk("R9", {claimN, errN, writeN}, exp);
    addrAckN = 1'b0;                              // start still low on release edge
    @(negedge clk);
    chk("R8", {claimN, errN, writeN}, 3'b111);
    startN = 1'b1; addrAckN = 1'b1;
    @(negedge clk);
    chk("R9", {claimN, errN, writeN}, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {claimN, errN, writeN}, 3'b111);
    rst = 1'b0;
    curReq = "R11";
    addrAckN = 1'b0;
    @(negedge clk);
    chk("R11", {claimN, errN, writeN}, 3'b111);
    addrAckN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", {claimN, errN, writeN}, 3'b111);
    for (int c = 0; c < 32; c++) xfer(5'(c), 1 + (c % 3));
    // idle start with a simultaneous acknowledge: the start must still be taken
    curReq = "R7";
    startN = 1'b0; addrAckN = 1'b0; ttCode = 5'b01010;
    @(negedge clk);
    chk("R7", {claimN, errN, writeN}, 3'b011);
    startN = 1'b1;
    @(negedge clk);
    chk("R8", {claimN, errN, writeN}, 3'b111);
    addrAckN = 1'b1;
    // back-to-back: new start on the cycle right after release
    xfer(5'b00110, 1);
    xfer(5'b11111, 1);
    // reset during a held transfer
    curReq = "R1";
    startN = 1'b0; ttCode = 5'b00010;
    @(negedge clk);
    startN = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R1", {claimN, errN, writeN}, 3'b111);
    rst = 1'b0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG_CYCLES) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule